// File: doc/BRIEF.md
# Configurable Complex Mixer Datapath

This block multiplies a complex sample stream by a carrier supplied as cosine and sine words from an external oscillator input. It forms the mixed in-phase and quadrature results through a cross-product adder stage. A two-bit source selector picks what feeds the multipliers: the complex sample pair, a real-only sample, an internal diagnostic ramp, or constant zero. Per-sample control bits choose round or truncate for every product, enable a doubling stage after the adders, and can drop the sine-weighted adder input so that only the cosine-weighted ("even") products reach the outputs.

All samples and carrier words are two's complement fractions. Each 12x12 product is scaled back to 12 bits by discarding its 11 low bits. The adder results leave on registered outputs two clock cycles after the sample was accepted, and a valid flag travels with them.

Top module: `cmix_top`

## Requirements
- R1: With `src_sel`=0, a valid sample gives `out_i` = P(I,cos) - P(Q,sin) and `out_q` = P(Q,cos) + P(I,sin), where P(x,y) is the 12-bit reduced product, and the sum is saturated to the signed 12-bit range.
- R2: With `src_sel`=1, `real_in` is used as the I operand and the Q operand is zero; `in_i` and `in_q` have no effect.
- R3: With `src_sel`=2, I and Q both take the value of a 12-bit ramp counter, read as signed. The counter is 0 after reset and increases by one, wrapping, after every cycle with `in_valid` high, whatever the source selection.
- R4: With `src_sel`=3, both outputs are zero for that sample.
- R5: With `rnd_en` low, each product is reduced as floor(x*y / 2048).
- R6: With `rnd_en` high, each product is reduced as floor((x*y + 1024) / 2048).
- R7: A reduced product that exceeds the signed 12-bit range, such as (-2048)*(-2048), saturates to 2047.
- R8: With `gain_en` high, the adder result is doubled, and then saturated to the range -2048..2047.
- R9: With `even_only` high, `out_i` = P(I,cos) and `out_q` = P(Q,cos), before the gain stage.
- R10: `out_valid` equals `in_valid` delayed by exactly two clock cycles, and the data of that sample is present in the same cycle.
- R11: While `rst` is high, `out_valid`, `out_i` and `out_q` are zero after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| src_sel | input | 2 | Source: 0 complex, 1 real, 2 ramp, 3 zero |
| rnd_en | input | 1 | Round products when high, truncate when low |
| gain_en | input | 1 | Doubling stage enable |
| even_only | input | 1 | Drop the sine-weighted adder input |
| in_i | input | 12 | Complex sample, in-phase |
| in_q | input | 12 | Complex sample, quadrature |
| real_in | input | 12 | Real-only sample |
| nco_cos | input | 12 | Carrier cosine word |
| nco_sin | input | 12 | Carrier sine word |
| out_valid | output | 1 | Output qualifier |
| out_i | output | 12 | Mixed in-phase result |
| out_q | output | 12 | Mixed quadrature result |

## Verification
The properties assume that every control bit is sampled together with its sample and that nothing about earlier samples carries into the pipeline except the ramp count. They also assume that reset is held for at least one edge before the first sample. The bench changes the controls only at sample boundaries, holds reset for two edges at start and in mid-run, and mixes idle cycles into every stream. This way the two-cycle valid alignment is tested under gaps as well as under back-to-back samples.

// File: rtl/cmix_pkg.sv
package cmix_pkg;
  typedef enum logic [1:0] {
    SRC_CPLX = 2'd0,
    SRC_REAL = 2'd1,
    SRC_RAMP = 2'd2,
    SRC_ZERO = 2'd3
  } src_sel_e;

  localparam int NPROD = 4;
  // product slots: 0 I*cos, 1 Q*sin, 2 I*sin, 3 Q*cos
  localparam int P_IC = 0;
  localparam int P_QS = 1;
  localparam int P_IS = 2;
  localparam int P_QC = 3;
endpackage

// File: rtl/cmix_src.sv
module cmix_src
  import cmix_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           src_sel,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic signed [DW-1:0] real_in,
  output logic signed [DW-1:0] src_i,
  output logic signed [DW-1:0] src_q
);
  logic [DW-1:0] ramp;

  always_ff @(posedge clk) begin
    if (rst)           ramp <= '0;
    else if (in_valid) ramp <= ramp + 1'b1;
  end

  always_comb begin
    unique case (src_sel_e'(src_sel))
      SRC_CPLX: begin src_i = in_i;            src_q = in_q;            end
      SRC_REAL: begin src_i = real_in;         src_q = '0;              end
      SRC_RAMP: begin src_i = $signed(ramp);   src_q = $signed(ramp);   end
      default:  begin src_i = '0;              src_q = '0;              end
    endcase
  end
endmodule

// File: rtl/cmix_prod.sv
module cmix_prod #(
  parameter int AW = 12,
  parameter int BW = 12,
  parameter int PW = 12
) (
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  input  logic                 rnd,
  output logic signed [PW-1:0] p
);
  localparam int FW = AW + BW;
  localparam int SH = FW - 1 - PW;

  logic signed [FW-1:0] full;
  logic signed [FW:0]   half, biased, shifted;

  always_comb begin
    full    = FW'(a) * FW'(b);
    half    = rnd ? ((FW+1)'(1) <<< (SH-1)) : '0;
    biased  = $signed({full[FW-1], full}) + half;
    shifted = biased >>> SH;
    if (shifted[FW:PW-1] == '0 || shifted[FW:PW-1] == '1)
      p = shifted[PW-1:0];
    else if (shifted[FW])
      p = {1'b1, {(PW-1){1'b0}}};
    else
      p = {1'b0, {(PW-1){1'b1}}};
  end
endmodule

// File: rtl/cmix_lane.sv
module cmix_lane #(
  parameter int PW  = 12,
  parameter int OW  = 12,
  parameter bit SUB = 1'b0
) (
  input  logic signed [PW-1:0] a,
  input  logic signed [PW-1:0] b,
  input  logic                 clr,
  input  logic                 gain,
  output logic signed [OW-1:0] y
);
  localparam int SW = PW + 2;

  logic signed [SW-1:0] ea, eb, sum, scaled;

  assign ea = SW'(a);
  assign eb = clr ? '0 : SW'(b);

  generate
    if (SUB) begin : g_sub
      assign sum = ea - eb;
    end else begin : g_add
      assign sum = ea + eb;
    end
  endgenerate

  always_comb begin
    scaled = gain ? (sum <<< 1) : sum;
    if (scaled[SW-1:OW-1] == '0 || scaled[SW-1:OW-1] == '1)
      y = scaled[OW-1:0];
    else if (scaled[SW-1])
      y = {1'b1, {(OW-1){1'b0}}};
    else
      y = {1'b0, {(OW-1){1'b1}}};
  end
endmodule

// File: rtl/cmix_top.sv
module cmix_top
  import cmix_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 12,
  parameter int PW = 12,
  parameter int OW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           src_sel,
  input  logic                 rnd_en,
  input  logic                 gain_en,
  input  logic                 even_only,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic signed [DW-1:0] real_in,
  input  logic signed [CW-1:0] nco_cos,
  input  logic signed [CW-1:0] nco_sin,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);
  logic signed [DW-1:0] src_i, src_q;
  logic signed [DW-1:0] opa [NPROD];
  logic signed [CW-1:0] opb [NPROD];
  logic signed [PW-1:0] prod [NPROD];
  logic signed [PW-1:0] prod_r [NPROD];
  logic                 v1, g1, c1;
  logic signed [OW-1:0] lane_i, lane_q;

  cmix_src #(.DW(DW)) u_src (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_sel(src_sel),
    .in_i(in_i), .in_q(in_q), .real_in(real_in),
    .src_i(src_i), .src_q(src_q)
  );

  always_comb begin
    opa[P_IC] = src_i; opb[P_IC] = nco_cos;
    opa[P_QS] = src_q; opb[P_QS] = nco_sin;
    opa[P_IS] = src_i; opb[P_IS] = nco_sin;
    opa[P_QC] = src_q; opb[P_QC] = nco_cos;
  end

  generate
    for (genvar k = 0; k < NPROD; k++) begin : g_prod
      cmix_prod #(.AW(DW), .BW(CW), .PW(PW)) u_prod (
        .a(opa[k]), .b(opb[k]), .rnd(rnd_en), .p(prod[k])
      );
      always_ff @(posedge clk) begin
        if (rst) prod_r[k] <= '0;
        else     prod_r[k] <= prod[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; g1 <= 1'b0; c1 <= 1'b0;
    end else begin
      v1 <= in_valid; g1 <= gain_en; c1 <= even_only;
    end
  end

  cmix_lane #(.PW(PW), .OW(OW), .SUB(1'b1)) u_lane_i (
    .a(prod_r[P_IC]), .b(prod_r[P_QS]), .clr(c1), .gain(g1), .y(lane_i)
  );
  cmix_lane #(.PW(PW), .OW(OW), .SUB(1'b0)) u_lane_q (
    .a(prod_r[P_QC]), .b(prod_r[P_IS]), .clr(c1), .gain(g1), .y(lane_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_i <= '0; out_q <= '0;
    end else begin
      out_valid <= v1; out_i <= lane_i; out_q <= lane_q;
    end
  end
endmodule

// File: rtl/cmix_chk.sv
module cmix_chk #(
  parameter int DW = 12,
  parameter int OW = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [1:0]           src_sel,
  input logic                 gain_en,
  input logic                 even_only,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_i,
  input logic signed [OW-1:0] out_q
);
  localparam logic signed [OW-1:0] OMAX = {1'b0, {(OW-1){1'b1}}};

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);
  a_r4_zero_source: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel == 2'd3) |=> ##1 (out_i == '0 && out_q == '0));
  a_r2_real_even_q: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel == 2'd1 && even_only) |=> ##1 (out_q == '0));
  a_r8_gain_even: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain_en) |=> ##1 (out_i[0] == 1'b0 || out_i == OMAX));
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0));
endmodule

bind cmix_top cmix_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src_sel(src_sel),
  .gain_en(gain_en), .even_only(even_only), .out_valid(out_valid),
  .out_i(out_i), .out_q(out_q)
);

// File: tb/tb_cmix_top.sv
module tb_cmix_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic rnd_en = 1'b0, gain_en = 1'b0, even_only = 1'b0;
  logic signed [11:0] in_i = '0, in_q = '0, real_in = '0, nco_cos = '0, nco_sin = '0;
  logic out_valid;
  logic signed [11:0] out_i, out_q;

  typedef struct { bit v; int i; int q; string tag; } exp_t;
  exp_t pend[$];
  int checks = 0, failures = 0, ramp_m = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmix_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_sel(src_sel),
    .rnd_en(rnd_en), .gain_en(gain_en), .even_only(even_only),
    .in_i(in_i), .in_q(in_q), .real_in(real_in),
    .nco_cos(nco_cos), .nco_sin(nco_sin),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic int sat12(int x);
    if (x > 2047) return 2047;
    if (x < -2048) return -2048;
    return x;
  endfunction

  function automatic int red(int a, int b, bit r);
    int p = a * b;
    if (r) p = p + 1024;
    return sat12(p >>> 11);
  endfunction

  function automatic int sx12(int v);
    return (v >= 2048) ? v - 4096 : v;
  endfunction

  task automatic check(string tag, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic compare_out();
    exp_t e;
    if (pend.size() < 2) return;
    e = pend.pop_front();
    check("R10", int'(out_valid), int'(e.v), "out_valid");
    if (e.v) begin
      check(e.tag, int'(out_i), e.i, "out_i");
      check(e.tag, int'(out_q), e.q, "out_q");
    end
  endtask

  task automatic step(string tag, bit v, int sel, int ii, int qq, int rr,
                      int c, int s, bit rnd, bit g, bit clr);
    exp_t e;
    int a, bq, pi, pq;
    @(negedge clk);
    compare_out();
    in_valid = v; src_sel = 2'(sel); in_i = 12'(ii); in_q = 12'(qq);
    real_in = 12'(rr); nco_cos = 12'(c); nco_sin = 12'(s);
    rnd_en = rnd; gain_en = g; even_only = clr;
    case (sel)
      0: begin a = ii; bq = qq; end
      1: begin a = rr; bq = 0; end
      2: begin a = sx12(ramp_m); bq = a; end
      default: begin a = 0; bq = 0; end
    endcase
    pi = red(a, c, rnd) - (clr ? 0 : red(bq, s, rnd));
    pq = red(bq, c, rnd) + (clr ? 0 : red(a, s, rnd));
    if (g) begin pi = pi * 2; pq = pq * 2; end
    e.v = v; e.i = sat12(pi); e.q = sat12(pq); e.tag = tag;
    pend.push_back(e);
    if (v) ramp_m = (ramp_m + 1) % 4096;
  endtask

  function automatic int rs();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    pend.delete();
    ramp_m = 0;
    repeat (2) @(negedge clk);
    check("R11", int'(out_valid), 0, "out_valid in reset");
    check("R11", int'(out_i), 0, "out_i in reset");
    check("R11", int'(out_q), 0, "out_q in reset");
    rst = 1'b0;
  endtask

  task automatic flush();
    repeat (3) step("R10", 1'b0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    do_reset();
    // R1 complex mixing with idle gaps
    for (int n = 0; n < 40; n++)
      step("R1", (n % 5) != 3, 0, rs(), rs(), rs(), rs(), rs(), 1'b0, 1'b0, 1'b0);
    // R2 real source, complex inputs must not matter
    for (int n = 0; n < 20; n++)
      step("R2", 1'b1, 1, rs(), rs(), rs(), rs(), rs(), n[0], 1'b0, n[1]);
    // R3 ramp with gaps and carrier giving exact negation
    for (int n = 0; n < 30; n++)
      step("R3", (n % 4) != 2, 2, rs(), rs(), rs(), -2048, 0, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 10; n++)
      step("R3", 1'b1, 2, 0, 0, 0, rs(), rs(), 1'b1, 1'b0, 1'b0);
    // R4 zero source
    for (int n = 0; n < 10; n++)
      step("R4", 1'b1, 3, rs(), rs(), rs(), rs(), rs(), n[0], n[1], 1'b0);
    // R5 / R6 half-LSB corner cases
    step("R5", 1'b1, 0, 3, 0, 0, 1024, 0, 1'b0, 1'b0, 1'b1);
    step("R5", 1'b1, 0, -3, 0, 0, 1024, 0, 1'b0, 1'b0, 1'b1);
    step("R5", 1'b1, 0, -1, 1, 0, 1, 0, 1'b0, 1'b0, 1'b1);
    step("R6", 1'b1, 0, 3, 0, 0, 1024, 0, 1'b1, 1'b0, 1'b1);
    step("R6", 1'b1, 0, -3, 0, 0, 1024, 0, 1'b1, 1'b0, 1'b1);
    step("R6", 1'b1, 0, 1, -1, 0, 1023, 0, 1'b1, 1'b0, 1'b1);
    for (int n = 0; n < 20; n++)
      step("R6", 1'b1, 0, rs(), rs(), 0, rs(), rs(), 1'b1, 1'b0, 1'b0);
    // R7 product overflow
    step("R7", 1'b1, 0, -2048, 0, 0, -2048, 0, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b1, 0, -2048, -2048, 0, -2048, -2048, 1'b1, 1'b0, 1'b0);
    step("R7", 1'b1, 0, -2048, 2047, 0, -2048, 2047, 1'b0, 1'b0, 1'b0);
    // R8 gain, including saturating values
    step("R8", 1'b1, 0, 2000, -2000, 0, 2000, 2000, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 0, -2000, 2000, 0, 2000, 2000, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 0, 100, 50, 0, 1024, 512, 1'b0, 1'b1, 1'b0);
    for (int n = 0; n < 20; n++)
      step("R8", n != 7, 0, rs(), rs(), 0, rs(), rs(), n[0], 1'b1, n[1]);
    // R9 even products only
    for (int n = 0; n < 20; n++)
      step("R9", 1'b1, 0, rs(), rs(), 0, rs(), rs(), n[0], 1'b0, 1'b1);
    flush();
    // R11 mid-run reset restarts the ramp
    for (int n = 0; n < 5; n++)
      step("R3", 1'b1, 2, 0, 0, 0, -2048, 0, 1'b0, 1'b0, 1'b0);
    do_reset();
    for (int n = 0; n < 6; n++)
      step("R11", 1'b1, 2, 0, 0, 0, -2048, 0, 1'b0, 1'b0, 1'b0);
    flush();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule